// File: doc/BRIEF.md
# Mode-Switched Processor Register File

This block holds the programmer-visible registers of an 8/16-bit processor core: the accumulator (low byte A and high byte B), the X and Y index registers, the direct page base D, the stack pointer S, the data and program bank registers, the 8-bit status word P, and a hidden emulation flag. A decoded micro-operation enters through `op_code` and `op_data`. It can load a register, move data between the accumulator and D or S, set or clear status bits through a mask, swap the accumulator bytes, or exchange the emulation flag with carry. All updates take effect on the next rising clock edge.

Register widths change while the core runs. Status bit 5 (accumulator width) and status bit 4 (index width) select 8 or 16 bits. While the emulation flag is 1, both bits are held at 1 and the stack is held in page one. Each read port shows its register at the width selected now. Instruction decode, arithmetic and bus sequencing happen in other blocks.

Top module: `cpu_regfile`

## Requirements
- R1: After reset the emulation flag is 1 and P reads 0x34. S reads 0x0100. A, B, X, Y, D and both bank registers read 0.
- R2: P bit 5 (m) selects the accumulator width and P bit 4 (x) selects the index width, with 1 meaning 8 bits. When m is 1, `rd_acc` shows A zero-extended. When m is 0, it shows {B,A}. A load of X or Y while x is 1 stores only the low byte of the data, with a zero high byte.
- R3: While the emulation flag is 1, m and x stay 1 whatever a set, clear or P load requests.
- R4: The exchange op (code 11) moves the old carry (P bit 0) into the emulation flag and the old emulation flag into carry, in one cycle.
- R5: When native mode is entered, the X and Y high bytes read 0 and B keeps its value.
- R6: Any update that takes x from 0 to 1 clears the X and Y high bytes in the same cycle. This covers a set op, a P load, and an exchange into emulation.
- R7: An accumulator load (code 1) writes only A when m is 1, and B keeps its value. When m is 0, it writes both B and A.
- R8: The byte swap (code 12) exchanges A and B for either value of m.
- R9: Accumulator-to-D (13), accumulator-to-S (14), D-to-accumulator (15) and S-to-accumulator (16) always move all 16 bits of {B,A}, whatever m is.
- R10: While the emulation flag is 1, the S high byte is forced to 0x01. This applies to S loads, to transfers into S, and on entry to emulation.
- R11: The set op (code 9) ORs `op_data[7:0]` into P. The clear op (code 10) clears the P bits that are 1 in `op_data[7:0]`.
- R12: The op codes are: 0 no-op, 1 load accumulator, 2 load X, 3 load Y, 4 load D, 5 load S, 6 load data bank, 7 load program bank, 8 load P. The bank loads take `op_data[7:0]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| op_code | input | 5 | Micro-operation code |
| op_data | input | 16 | Operand data or status mask |
| rd_acc | output | 16 | Accumulator at the selected width |
| rd_acc_full | output | 16 | {B,A} regardless of width |
| rd_x | output | 16 | X index |
| rd_y | output | 16 | Y index |
| rd_d | output | 16 | Direct page base |
| rd_s | output | 16 | Stack pointer |
| rd_dbr | output | 8 | Data bank |
| rd_pbr | output | 8 | Program bank |
| rd_p | output | 8 | Status word |
| rd_emu | output | 1 | Hidden emulation flag |

## Verification
The table drives loads of the same values while the core sits in emulation, in native with wide registers, and in native with narrow registers. Comparing the readback across these three states shows whether a width bit or the emulation flag is gating each write. Mode exchanges are tried in both directions and with x both set and clear beforehand. This separates high-byte clearing caused by a rise of x from clearing caused by the exchange itself, and it confirms that B survives the change. Transfers with m set show whether the 16-bit moves honour the width bit by mistake.

// File: rtl/regfile_pkg.sv
package regfile_pkg;
   typedef enum logic [4:0] {
      OP_NOP  = 5'd0,
      OP_LDA  = 5'd1,
      OP_LDX  = 5'd2,
      OP_LDY  = 5'd3,
      OP_LDD  = 5'd4,
      OP_LDS  = 5'd5,
      OP_LDDB = 5'd6,
      OP_LDPB = 5'd7,
      OP_LDP  = 5'd8,
      OP_SETM = 5'd9,
      OP_CLRM = 5'd10,
      OP_XCHE = 5'd11,
      OP_SWAB = 5'd12,
      OP_A2D  = 5'd13,
      OP_A2S  = 5'd14,
      OP_D2A  = 5'd15,
      OP_S2A  = 5'd16
   } rf_op_e;

   localparam int P_CARRY = 0;
   localparam int P_XW    = 4;
   localparam int P_MW    = 5;
   localparam logic [7:0] P_RESET = 8'h34;
endpackage

// File: rtl/regfile_status.sv
module regfile_status
   import regfile_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  rf_op_e     op,
   input  logic [7:0] mask,
   output logic [7:0] p_q,
   output logic       e_q,
   output logic       e_nx,
   output logic       clr_hi
);
   logic [7:0] p_nx;

   always_comb begin
      p_nx = p_q;
      e_nx = e_q;
      unique case (op)
         OP_LDP:  p_nx = mask;
         OP_SETM: p_nx = p_q | mask;
         OP_CLRM: p_nx = p_q & ~mask;
         OP_XCHE: begin
            e_nx           = p_q[P_CARRY];
            p_nx[P_CARRY]  = e_q;
         end
         default: ;
      endcase
      if (e_nx) begin
         p_nx[P_MW] = 1'b1;
         p_nx[P_XW] = 1'b1;
      end
      clr_hi = p_nx[P_XW] & ~p_q[P_XW];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         p_q <= P_RESET;
         e_q <= 1'b1;
      end else begin
         p_q <= p_nx;
         e_q <= e_nx;
      end
   end
endmodule

// File: rtl/regfile_index.sv
module regfile_index #(
   parameter int BYTE_W = 8
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                ld,
   input  logic [2*BYTE_W-1:0] din,
   input  logic                narrow,
   input  logic                clr_hi,
   output logic [2*BYTE_W-1:0] q
);
   localparam int WORD_W = 2 * BYTE_W;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         q <= '0;
      end else if (ld) begin
         q <= narrow ? {{BYTE_W{1'b0}}, din[BYTE_W-1:0]} : din;
      end else if (clr_hi) begin
         q[WORD_W-1:BYTE_W] <= '0;
      end
   end
endmodule

// File: rtl/cpu_regfile.sv
module cpu_regfile
   import regfile_pkg::*;
#(
   parameter int BYTE_W     = 8,
   parameter int BANK_W     = 8,
   parameter int STACK_PAGE = 1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [4:0]          op_code,
   input  logic [2*BYTE_W-1:0] op_data,
   output logic [2*BYTE_W-1:0] rd_acc,
   output logic [2*BYTE_W-1:0] rd_acc_full,
   output logic [2*BYTE_W-1:0] rd_x,
   output logic [2*BYTE_W-1:0] rd_y,
   output logic [2*BYTE_W-1:0] rd_d,
   output logic [2*BYTE_W-1:0] rd_s,
   output logic [BANK_W-1:0]   rd_dbr,
   output logic [BANK_W-1:0]   rd_pbr,
   output logic [7:0]          rd_p,
   output logic                rd_emu
);
   localparam int WORD_W = 2 * BYTE_W;
   localparam logic [BYTE_W-1:0] S_PAGE = BYTE_W'(STACK_PAGE);

   if (BYTE_W < 8)                        $error("BYTE_W must hold the status mask");
   if (BANK_W < 1 || BANK_W > WORD_W)     $error("BANK_W out of range");
   if (STACK_PAGE < 0 || STACK_PAGE >= (1 << BYTE_W)) $error("STACK_PAGE out of range");

   rf_op_e op;
   assign op = rf_op_e'(op_code);

   logic [7:0] p_q;
   logic       e_q, e_nx, clr_hi;

   regfile_status i_status (
      .clk(clk), .rst_n(rst_n), .op(op), .mask(op_data[7:0]),
      .p_q(p_q), .e_q(e_q), .e_nx(e_nx), .clr_hi(clr_hi)
   );

   logic m8, x8;
   assign m8 = p_q[P_MW];
   assign x8 = p_q[P_XW];

   // accumulator halves
   logic [BYTE_W-1:0] a_q, b_q;
   logic [WORD_W-1:0] d_q, s_q, s_nx;
   logic [BANK_W-1:0] dbr_q, pbr_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         a_q <= '0;
         b_q <= '0;
      end else begin
         unique case (op)
            OP_LDA: begin
               a_q <= op_data[BYTE_W-1:0];
               if (!m8) b_q <= op_data[WORD_W-1:BYTE_W];
            end
            OP_SWAB: begin
               a_q <= b_q;
               b_q <= a_q;
            end
            OP_D2A: {b_q, a_q} <= d_q;
            OP_S2A: {b_q, a_q} <= s_q;
            default: ;
         endcase
      end
   end

   // index registers share one structure
   logic [WORD_W-1:0] idx_q [2];
   for (genvar g = 0; g < 2; g++) begin : g_idx
      regfile_index #(.BYTE_W(BYTE_W)) i_idx (
         .clk(clk), .rst_n(rst_n),
         .ld(op == (g == 0 ? OP_LDX : OP_LDY)),
         .din(op_data), .narrow(x8), .clr_hi(clr_hi),
         .q(idx_q[g])
      );
   end

   always_comb begin
      s_nx = s_q;
      if (op == OP_LDS) s_nx = op_data;
      if (op == OP_A2S) s_nx = {b_q, a_q};
      if (e_nx) s_nx[WORD_W-1:BYTE_W] = S_PAGE;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         d_q   <= '0;
         s_q   <= {S_PAGE, {BYTE_W{1'b0}}};
         dbr_q <= '0;
         pbr_q <= '0;
      end else begin
         s_q <= s_nx;
         if (op == OP_LDD)  d_q   <= op_data;
         if (op == OP_A2D)  d_q   <= {b_q, a_q};
         if (op == OP_LDDB) dbr_q <= op_data[BANK_W-1:0];
         if (op == OP_LDPB) pbr_q <= op_data[BANK_W-1:0];
      end
   end

   assign rd_acc      = m8 ? {{BYTE_W{1'b0}}, a_q} : {b_q, a_q};
   assign rd_acc_full = {b_q, a_q};
   assign rd_x        = idx_q[0];
   assign rd_y        = idx_q[1];
   assign rd_d        = d_q;
   assign rd_s        = s_q;
   assign rd_dbr      = dbr_q;
   assign rd_pbr      = pbr_q;
   assign rd_p        = p_q;
   assign rd_emu      = e_q;
endmodule

// File: rtl/regfile_chk.sv
module regfile_chk
   import regfile_pkg::*;
#(
   parameter int BYTE_W     = 8,
   parameter int STACK_PAGE = 1
) (
   input logic                clk,
   input logic                rst_n,
   input logic [4:0]          op_code,
   input logic [7:0]          rd_p,
   input logic                rd_emu,
   input logic [2*BYTE_W-1:0] rd_s,
   input logic [2*BYTE_W-1:0] rd_x,
   input logic [2*BYTE_W-1:0] rd_y,
   input logic [2*BYTE_W-1:0] rd_acc_full
);
   localparam int WORD_W = 2 * BYTE_W;

   AST_EMU_WIDTHS: assert property (@(posedge clk) disable iff (!rst_n)
      rd_emu |-> (rd_p[P_MW] && rd_p[P_XW])); // R3

   AST_EMU_STACK: assert property (@(posedge clk) disable iff (!rst_n)
      rd_emu |-> (rd_s[WORD_W-1:BYTE_W] == BYTE_W'(STACK_PAGE))); // R10

   AST_IDX_NARROW: assert property (@(posedge clk) disable iff (!rst_n)
      rd_p[P_XW] |-> (rd_x[WORD_W-1:BYTE_W] == '0 && rd_y[WORD_W-1:BYTE_W] == '0)); // R6

   AST_B_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
      (op_code == OP_LDA && rd_p[P_MW]) |=> $stable(rd_acc_full[WORD_W-1:BYTE_W])); // R7

   AST_XCHE_SWAP: assert property (@(posedge clk) disable iff (!rst_n)
      (op_code == OP_XCHE) |=> (rd_emu == $past(rd_p[P_CARRY]) && rd_p[P_CARRY] == $past(rd_emu))); // R4

   AST_SWAB: assert property (@(posedge clk) disable iff (!rst_n)
      (op_code == OP_SWAB) |=> (rd_acc_full == {$past(rd_acc_full[BYTE_W-1:0]), $past(rd_acc_full[WORD_W-1:BYTE_W])})); // R8
endmodule

bind cpu_regfile regfile_chk #(.BYTE_W(BYTE_W), .STACK_PAGE(STACK_PAGE)) i_chk (
   .clk(clk), .rst_n(rst_n), .op_code(op_code), .rd_p(rd_p), .rd_emu(rd_emu),
   .rd_s(rd_s), .rd_x(rd_x), .rd_y(rd_y), .rd_acc_full(rd_acc_full)
);

// File: tb/test_cpu_regfile.sv
module test_cpu_regfile;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [4:0]  op_code = 5'd0;
   logic [15:0] op_data = 16'h0;
   logic [15:0] rd_acc, rd_acc_full, rd_x, rd_y, rd_d, rd_s;
   logic [7:0]  rd_dbr, rd_pbr, rd_p;
   logic        rd_emu;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #4 clk = ~clk;

   cpu_regfile i_cpu_regfile (
      .clk(clk), .rst_n(rst_n), .op_code(op_code), .op_data(op_data),
      .rd_acc(rd_acc), .rd_acc_full(rd_acc_full), .rd_x(rd_x), .rd_y(rd_y),
      .rd_d(rd_d), .rd_s(rd_s), .rd_dbr(rd_dbr), .rd_pbr(rd_pbr),
      .rd_p(rd_p), .rd_emu(rd_emu)
   );

   // entry: op(5) data(16) sel(4) expected(16) req(4)
   localparam int NV = 32;
   localparam logic [44:0] VEC [NV] = '{
      {5'd1,  16'h1234, 4'd1, 16'h0034, 4'd7},  // R7 emu load keeps B
      {5'd10, 16'h0030, 4'd8, 16'h0034, 4'd3},  // R3 clear ignored
      {5'd2,  16'hABCD, 4'd2, 16'h00CD, 4'd2},  // R2 narrow index load
      {5'd5,  16'h55AA, 4'd5, 16'h01AA, 4'd10}, // R10 stack page
      {5'd10, 16'h0001, 4'd8, 16'h0034, 4'd11}, // R11 clear carry
      {5'd11, 16'h0000, 4'd9, 16'h0000, 4'd4},  // R4 enter native
      {5'd0,  16'h0000, 4'd8, 16'h0035, 4'd4},  // R4 carry took old flag
      {5'd10, 16'h0030, 4'd8, 16'h0005, 4'd11}, // R11 widen both
      {5'd1,  16'hBEEF, 4'd0, 16'hBEEF, 4'd7},  // R7 wide load
      {5'd2,  16'h1234, 4'd2, 16'h1234, 4'd2},  // R2 wide X
      {5'd3,  16'h5678, 4'd3, 16'h5678, 4'd2},  // R2 wide Y
      {5'd9,  16'h0010, 4'd2, 16'h0034, 4'd6},  // R6 x rise clears X
      {5'd0,  16'h0000, 4'd3, 16'h0078, 4'd6},  // R6 and Y
      {5'd9,  16'h0020, 4'd0, 16'h00EF, 4'd2},  // R2 narrow acc read
      {5'd1,  16'h0011, 4'd1, 16'hBE11, 4'd7},  // R7 B kept
      {5'd12, 16'h0000, 4'd1, 16'h11BE, 4'd8},  // R8 swap with m=1
      {5'd14, 16'h0000, 4'd5, 16'h11BE, 4'd9},  // R9 acc to S
      {5'd4,  16'h2468, 4'd4, 16'h2468, 4'd12}, // R12 load D
      {5'd15, 16'h0000, 4'd1, 16'h2468, 4'd9},  // R9 D to acc
      {5'd16, 16'h0000, 4'd1, 16'h11BE, 4'd9},  // R9 S to acc
      {5'd13, 16'h0000, 4'd4, 16'h11BE, 4'd9},  // R9 acc to D
      {5'd6,  16'h77C3, 4'd6, 16'h00C3, 4'd12}, // R12 data bank
      {5'd7,  16'h0099, 4'd7, 16'h0099, 4'd12}, // R12 program bank
      {5'd10, 16'h0010, 4'd8, 16'h0025, 4'd11}, // R11 widen index
      {5'd2,  16'hFF01, 4'd2, 16'hFF01, 4'd2},  // R2
      {5'd11, 16'h0000, 4'd9, 16'h0001, 4'd4},  // R4 back to emulation
      {5'd0,  16'h0000, 4'd2, 16'h0001, 4'd6},  // R6 exchange clears X high
      {5'd0,  16'h0000, 4'd5, 16'h01BE, 4'd10}, // R10 entry forces page
      {5'd0,  16'h0000, 4'd8, 16'h0034, 4'd4},  // R4 carry cleared, R3 widths
      {5'd0,  16'h0000, 4'd1, 16'h11BE, 4'd8},  // R8 B survives
      {5'd8,  16'h0000, 4'd8, 16'h0030, 4'd3},  // R3 P load keeps widths
      {5'd4,  16'h8001, 4'd4, 16'h8001, 4'd12}  // R12
   };

   function automatic logic [15:0] pick(input logic [3:0] sel);
      case (sel)
         4'd0: return rd_acc;
         4'd1: return rd_acc_full;
         4'd2: return rd_x;
         4'd3: return rd_y;
         4'd4: return rd_d;
         4'd5: return rd_s;
         4'd6: return {8'h00, rd_dbr};
         4'd7: return {8'h00, rd_pbr};
         4'd8: return {8'h00, rd_p};
         default: return {15'h0, rd_emu};
      endcase
   endfunction

   task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic step(input logic [4:0] o, input logic [15:0] d);
      @(negedge clk);
      op_code = o;
      op_data = d;
      @(negedge clk);
      op_code = 5'd0;
      op_data = 16'h0;
   endtask

   task automatic reset_checks();
      check("R1", rd_acc_full, 16'h0000);
      check("R1", rd_x, 16'h0000);
      check("R1", rd_y, 16'h0000);
      check("R1", rd_d, 16'h0000);
      check("R1", rd_s, 16'h0100);
      check("R1", {8'h0, rd_dbr}, 16'h0000);
      check("R1", {8'h0, rd_pbr}, 16'h0000);
      check("R1", {8'h0, rd_p}, 16'h0034);
      check("R1", {15'h0, rd_emu}, 16'h0001);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      reset_checks();
      rst_n = 1'b1;
      for (int i = 0; i < NV; i++) begin
         step(VEC[i][44:40], VEC[i][39:24]);
         check($sformatf("R%0d vec %0d", VEC[i][3:0], i), pick(VEC[i][23:20]), VEC[i][19:4]);
      end
      // R5: enter native from emulation, carry is 0 here
      step(5'd11, 16'h0);
      check("R5", {15'h0, rd_emu}, 16'h0000);
      check("R5", rd_acc_full, 16'h11BE);
      check("R5", rd_x, 16'h0001);
      // R1: reset in the middle of a run
      step(5'd1, 16'hCAFE);
      @(negedge clk);
      rst_n = 1'b0;
      @(negedge clk);
      reset_checks();
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (5000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog actual hung expected done");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end
endmodule